// File: doc/BRIEF.md
# Microcode Step and Address-Match Halt Controller

This controller sits between a free-running clock domain and the clock enable of a microcoded sequencer. It decides, cycle by cycle, whether the sequencer may advance. Three modes are available. In run mode the sequencer advances every cycle. In manual mode it advances once for each operator press of a manual-clock button. In stop mode it runs until its current microaddress equals the low byte of the operator switch register, and then it freezes.

A match flag reports the address comparison in every mode. Two display registers record, for the most recent advance, the microaddress that was executed and the base microaddress that follows it. Stepping the sequencer and reading both values at each step produces a trace of the microcode flow. A halt caused by a match is latched. It is released by clearing the stop enable or by a single manual press.

Top module: `ustep_ctl`

## Requirements
- R1: While rst_n is low, both display registers are cleared to zero and any latched halt is cleared. After release in stop mode, a non-matching address lets the sequencer run.
- R2: With man_en and stop_en both low, seq_ce is 1 in every cycle.
- R3: match is 1 exactly when cur_addr equals sw_reg[7:0] and is independent of sw_reg[15:8]. This holds in every mode.
- R4: With man_en high, seq_ce is 1 for exactly one cycle per rising edge of man_clk and is 0 otherwise. The pulse is seen in the cycle after the second clock edge following the rise. Holding man_clk high or releasing it produces no further pulse.
- R5: man_en takes priority over stop_en. When both are high, the block behaves as in manual mode.
- R6: In stop mode (man_en low, stop_en high), seq_ce is 1 while there is no match and no latched halt. seq_ce drops to 0 in the same cycle that match becomes 1.
- R7: Once halted, the block stays halted even if the switch register stops matching. Clearing stop_en restores seq_ce to 1 in the same cycle and discards the halt.
- R8: A manual-clock press while halted in stop mode gives one cycle of seq_ce. It clears the latched halt, so the sequencer keeps running if the address no longer matches.
- R9: At every clock edge where seq_ce is 1, prev_disp loads cur_addr and next_disp loads nxt_addr. At all other edges both registers hold their value.
- R10: halted is 1 exactly when the block is in stop mode and seq_ce is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_en | input | 1 | Manual single-step mode enable |
| man_clk | input | 1 | Debounced manual-clock button level (asynchronous) |
| stop_en | input | 1 | Stop-on-address-match enable |
| sw_reg | input | 16 | Console switch register; the low 8 bits are the compare value |
| cur_addr | input | 8 | Sequencer current microaddress |
| nxt_addr | input | 8 | Sequencer next (base) microaddress |
| seq_ce | output | 1 | Clock enable to the sequencer |
| match | output | 1 | Current microaddress equals the switch compare value |
| halted | output | 1 | Stop mode is holding the sequencer |
| prev_disp | output | 8 | Microaddress executed at the most recent advance |
| next_disp | output | 8 | Next microaddress captured at the most recent advance |

## Verification
The hardest state to reach is a latched halt whose original cause has gone away. The switch register must first equal the current address in stop mode, and must then be moved off it while the sequencer is frozen. Only the latch can then explain why seq_ce stays low. The bench drives into that state in sequence, then releases it in two ways: with a manual press (one step pulse, then free running), and by dropping stop_en. Each release is timed against the two-stage synchronizer latency of the press.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

  localparam int UA_W_DEF  = 8;
  localparam int SR_W_DEF  = 16;
  localparam int SYNC_DEF  = 2;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STEP = 2'd1,
    MODE_STOP = 2'd2
  } step_mode_e;

  // Manual stepping outranks stop-on-match; neither means free run.
  function automatic step_mode_e pick_mode(input logic man, input logic stop);
    if (man)       return MODE_STEP;
    else if (stop) return MODE_STOP;
    else           return MODE_RUN;
  endfunction

  // Equality written as an all-zero difference so the bench can phrase it differently.
  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] b);
    return ((a ^ b) == 32'd0);
  endfunction

endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
  parameter int STAGES = ustep_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      last_q <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ustep_cmp.sv
module ustep_cmp #(
  parameter int UA_W = ustep_pkg::UA_W_DEF
) (
  input  logic [UA_W-1:0] addr,
  input  logic [UA_W-1:0] ref_val,
  output logic            hit
);
  assign hit = ustep_pkg::addr_hit(32'(addr), 32'(ref_val));
endmodule

// File: rtl/ustep_gate.sv
module ustep_gate
  import ustep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic man_en,
  input  logic stop_en,
  input  logic hit,
  input  logic step_pulse,
  output logic ce,
  output logic halted,
  output logic halt_q
);
  step_mode_e mode;
  logic       halt_d;

  assign mode = pick_mode(man_en, stop_en);

  always_comb begin
    ce     = 1'b1;
    halt_d = 1'b0;
    unique case (mode)
      MODE_STEP: ce = step_pulse;
      MODE_STOP: begin
        ce     = step_pulse | ~(hit | halt_q);
        halt_d = step_pulse ? 1'b0 : (hit | halt_q);
      end
      default: ce = 1'b1;
    endcase
  end

  assign halted = (mode == MODE_STOP) & ~ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end
endmodule

// File: rtl/ustep_trace.sv
module ustep_trace #(
  parameter int UA_W = ustep_pkg::UA_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic [UA_W-1:0] cur,
  input  logic [UA_W-1:0] nxt,
  output logic [UA_W-1:0] prev_q,
  output logic [UA_W-1:0] next_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      next_q <= '0;
    end else if (ce) begin
      prev_q <= cur;
      next_q <= nxt;
    end
  end
endmodule

// File: rtl/ustep_ctl.sv
module ustep_ctl #(
  parameter int UA_W        = ustep_pkg::UA_W_DEF,
  parameter int SR_W        = ustep_pkg::SR_W_DEF,
  parameter int SYNC_STAGES = ustep_pkg::SYNC_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            man_en,
  input  logic            man_clk,
  input  logic            stop_en,
  input  logic [SR_W-1:0] sw_reg,
  input  logic [UA_W-1:0] cur_addr,
  input  logic [UA_W-1:0] nxt_addr,
  output logic            seq_ce,
  output logic            match,
  output logic            halted,
  output logic [UA_W-1:0] prev_disp,
  output logic [UA_W-1:0] next_disp
);
  localparam int HI_W = SR_W - UA_W;

  // Named internal events, visible to the bound checker.
  logic            step_pulse;
  logic            halt_q;
  logic [UA_W-1:0] sw_cmp;

  assign sw_cmp = sw_reg[UA_W-1:0];

  generate
    if (HI_W > 0) begin : g_hi
      logic sw_hi_unused;
      assign sw_hi_unused = ^sw_reg[SR_W-1:UA_W];
    end
  endgenerate

  ustep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (man_clk), .rise (step_pulse)
  );

  ustep_cmp #(.UA_W(UA_W)) u_cmp (
    .addr (cur_addr), .ref_val (sw_cmp), .hit (match)
  );

  ustep_gate u_gate (
    .clk (clk), .rst_n (rst_n), .man_en (man_en), .stop_en (stop_en),
    .hit (match), .step_pulse (step_pulse),
    .ce (seq_ce), .halted (halted), .halt_q (halt_q)
  );

  ustep_trace #(.UA_W(UA_W)) u_trace (
    .clk (clk), .rst_n (rst_n), .ce (seq_ce),
    .cur (cur_addr), .nxt (nxt_addr),
    .prev_q (prev_disp), .next_q (next_disp)
  );
endmodule

// File: rtl/ustep_ctl_chk.sv
module ustep_ctl_chk #(
  parameter int UA_W = ustep_pkg::UA_W_DEF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            man_en,
  input logic            stop_en,
  input logic            seq_ce,
  input logic            match,
  input logic            halted,
  input logic            step_pulse,
  input logic [UA_W-1:0] cur_addr,
  input logic [UA_W-1:0] nxt_addr,
  input logic [UA_W-1:0] prev_disp,
  input logic [UA_W-1:0] next_disp
);
  // R2
  run_mode_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && !stop_en) |-> seq_ce);

  // R4
  step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (man_en && !step_pulse) |-> !seq_ce);

  // R4
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (man_en && seq_ce) |=> (!seq_ce || !man_en));

  // R6
  stop_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && stop_en && match && !step_pulse) |-> !seq_ce);

  // R9
  trace_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ce |=> (prev_disp == $past(cur_addr) && next_disp == $past(nxt_addr)));

  // R9
  trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ce |=> ($stable(prev_disp) && $stable(next_disp)));

  // R10
  halted_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!seq_ce && stop_en && !man_en));
endmodule

bind ustep_ctl ustep_ctl_chk #(.UA_W(UA_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .man_en (man_en), .stop_en (stop_en),
  .seq_ce (seq_ce), .match (match), .halted (halted), .step_pulse (step_pulse),
  .cur_addr (cur_addr), .nxt_addr (nxt_addr),
  .prev_disp (prev_disp), .next_disp (next_disp)
);

// File: tb/ustep_ctl_bench.sv
`timescale 1ns/1ps
module ustep_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_en = 1'b0, man_clk = 1'b0, stop_en = 1'b0;
  logic [15:0] sw_reg = '0;
  logic [7:0]  cur_addr = '0, nxt_addr = '0;
  logic        seq_ce, match, halted;
  logic [7:0]  prev_disp, next_disp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ustep_ctl u_ustep_ctl (
    .clk (clk), .rst_n (rst_n), .man_en (man_en), .man_clk (man_clk),
    .stop_en (stop_en), .sw_reg (sw_reg), .cur_addr (cur_addr),
    .nxt_addr (nxt_addr), .seq_ce (seq_ce), .match (match),
    .halted (halted), .prev_disp (prev_disp), .next_disp (next_disp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        man;
    logic        stop;
    logic [15:0] sw;
    logic [7:0]  cur;
    logic [7:0]  nxt;
    logic        ce;
    logic        mt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 16'h0012, 8'h12, 8'h34, 1'b1, 1'b1},
    '{1'b0, 1'b0, 16'hFF12, 8'h12, 8'h35, 1'b1, 1'b1},
    '{1'b0, 1'b0, 16'h0012, 8'h13, 8'h36, 1'b1, 1'b0},
    '{1'b0, 1'b0, 16'h00FF, 8'hFF, 8'h00, 1'b1, 1'b1},
    '{1'b1, 1'b0, 16'h0000, 8'h00, 8'h11, 1'b0, 1'b1},
    '{1'b1, 1'b1, 16'h0000, 8'h00, 8'h22, 1'b0, 1'b1},
    '{1'b0, 1'b1, 16'h0040, 8'h3F, 8'h40, 1'b1, 1'b0},
    '{1'b0, 1'b1, 16'h0040, 8'h41, 8'h42, 1'b1, 1'b0}
  };

  // Expected match, restated independently as a per-bit comparison.
  function automatic logic exp_match(input logic [15:0] sw, input logic [7:0] a);
    for (int b = 0; b < 8; b++) if (sw[b] != a[b]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ep, en;
    int cnt, at;
    ep = '0; en = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 prev_disp in reset", 32'(prev_disp), 0);
    check("R1 next_disp in reset", 32'(next_disp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R2, R3, R5, R6, R9
    for (int i = 0; i < NV; i++) begin
      check($sformatf("R9 prev_disp row %0d", i), 32'(prev_disp), 32'(ep));
      check($sformatf("R9 next_disp row %0d", i), 32'(next_disp), 32'(en));
      man_en = TBL[i].man; stop_en = TBL[i].stop; sw_reg = TBL[i].sw;
      cur_addr = TBL[i].cur; nxt_addr = TBL[i].nxt;
      #1;
      check($sformatf("R2/R5/R6 seq_ce row %0d", i), 32'(seq_ce), 32'(TBL[i].ce));
      check($sformatf("R3 match row %0d", i), 32'(match), 32'(TBL[i].mt));
      check($sformatf("R3 match model row %0d", i), 32'(match),
            32'(exp_match(TBL[i].sw, TBL[i].cur)));
      if (TBL[i].ce) begin ep = TBL[i].cur; en = TBL[i].nxt; end
      @(negedge clk);
    end

    // R4: manual press gives one pulse, at the second edge after the rise
    man_en = 1'b1; stop_en = 1'b0; cur_addr = 8'h5A; nxt_addr = 8'h5B;
    repeat (3) @(negedge clk);
    man_clk = 1'b1; cnt = 0; at = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (seq_ce) begin cnt++; at = k; end
    end
    check("R4 pulses per press", 32'(cnt), 1);
    check("R4 pulse cycle", 32'(at), 2);
    check("R9 prev after step", 32'(prev_disp), 32'h5A);
    check("R9 next after step", 32'(next_disp), 32'h5B);
    man_clk = 1'b0; cnt = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (seq_ce) cnt++;
    end
    check("R4 no pulse on release", 32'(cnt), 0);
    cur_addr = 8'h60; nxt_addr = 8'h61;
    man_clk = 1'b1; cnt = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (seq_ce) cnt++;
    end
    check("R4 second press pulses", 32'(cnt), 1);
    check("R9 prev after second step", 32'(prev_disp), 32'h60);
    man_clk = 1'b0;
    repeat (4) @(negedge clk);

    // R6 / R7 / R10: stop on match and latched halt
    man_en = 1'b0; stop_en = 1'b1; sw_reg = 16'h0020; cur_addr = 8'h10; nxt_addr = 8'h11;
    #1;
    check("R6 runs without match", 32'(seq_ce), 1);
    check("R10 not halted", 32'(halted), 0);
    @(negedge clk);
    cur_addr = 8'h20; nxt_addr = 8'h21;
    #1;
    check("R6 ce drops on match", 32'(seq_ce), 0);
    check("R10 halted on match", 32'(halted), 1);
    @(negedge clk);
    sw_reg = 16'h0055;
    #1;
    check("R3 match off after switch change", 32'(match), 0);
    check("R7 halt persists", 32'(seq_ce), 0);
    check("R10 halted persists", 32'(halted), 1);
    repeat (3) @(negedge clk);
    check("R7 halt still held", 32'(seq_ce), 0);
    check("R9 prev held while halted", 32'(prev_disp), 32'h10);

    // R8: manual press releases the halt
    man_clk = 1'b1;
    @(negedge clk);
    check("R8 no step yet", 32'(seq_ce), 0);
    @(negedge clk);
    check("R8 step pulse", 32'(seq_ce), 1);
    check("R10 not halted during step", 32'(halted), 0);
    @(negedge clk);
    check("R8 runs after step", 32'(seq_ce), 1);
    check("R9 prev after stop step", 32'(prev_disp), 32'h20);
    man_clk = 1'b0;
    @(negedge clk);

    // R7: clearing stop_en releases immediately
    sw_reg = 16'h0020;
    #1;
    check("R6 halt again", 32'(seq_ce), 0);
    @(negedge clk);
    sw_reg = 16'h0055;
    @(negedge clk);
    stop_en = 1'b0;
    #1;
    check("R7 clear stop_en ce", 32'(seq_ce), 1);
    check("R10 clear stop_en halted", 32'(halted), 0);
    @(negedge clk);
    stop_en = 1'b1;
    #1;
    check("R7 halt discarded", 32'(seq_ce), 1);

    // R1: reset clears a latched halt
    @(negedge clk);
    sw_reg = 16'h0020;
    @(negedge clk);
    sw_reg = 16'h0055;
    #1;
    check("R7 halted before reset", 32'(halted), 1);
    rst_n = 1'b0;
    #1;
    check("R1 prev cleared", 32'(prev_disp), 0);
    check("R1 next cleared", 32'(next_disp), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 halt cleared", 32'(seq_ce), 1);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule